// File: doc/BRIEF.md
# Performance Counter Freeze Controller

This block holds a 32-bit monitor control word and uses it to decide, every cycle, whether two event counters may advance. The word is written only from the privileged (supervisor) state. A read-only copy of the same contents is offered to user-level code, and reading either copy never changes the word. Counting stops under any of five independent freeze conditions: a global freeze, freeze while privileged, freeze while in user state, freeze while the process mark is set, and freeze while the process mark is clear.

Hardware also changes the word by itself. An enabled condition arises in two ways: a counter's top bit turns on while that counter's condition-enable bit is set, or an external condition pulse arrives. When such a condition occurs and the freeze-on-condition bit is set, the hardware sets the global freeze bit. When the condition occurs and the exception enable is set, the block raises an interrupt request. When the interrupt is taken, the hardware clears the exception enable. A sample-address update enable tells the surrounding logic when the sampled address may be refreshed.

Top module: `pmon_freeze_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the control word, both counters, irq_req and priv_viol read zero.
- R2: A write with wr_en=1 and priv_user=0 stores wr_data into the word, visible one cycle later. Bit numbering is big-endian: field bit n sits at vector index 31-n. ctrl_user_q always equals ctrl_q, and idle cycles leave the word unchanged.
- R3: A write with priv_user=1 leaves the word unchanged and pulses priv_viol for exactly the next cycle.
- R4: While the global freeze bit (bit 0, index 31) is 1, count_en and sample_upd_en are 0. sample_upd_en equals the inverse of that bit.
- R5: Bit 1 (index 30) forces count_en low while priv_user=0. Bit 2 (index 29) forces count_en low while priv_user=1.
- R6: Bit 3 (index 28) forces count_en low while proc_mark=1. Bit 4 (index 27) forces count_en low while proc_mark=0.
- R7: count_en is the AND of all negated freeze conditions, combinationally, in the same cycle. Counter k advances by one, wrapping modulo 2^CNT_W, on the edge after a cycle in which evt[k] and count_en are both 1, and holds otherwise.
- R8: An enabled condition is ext_cond=1, or counter k stepping from 2^(CNT_W-1)-1 to 2^(CNT_W-1) while its enable bit is set (counter 0 uses bit 16, index 15; counter 1 uses bit 17, index 14). If the freeze-on-condition bit (bit 6, index 25) is 1 in that cycle, the global freeze bit is 1 on the next cycle.
- R9: irq_req pulses high on the cycle after an enabled condition if the exception enable (bit 5, index 26) was 1 in the condition's cycle. It stays low otherwise.
- R10: irq_taken=1 makes the exception-enable bit 0 on the next cycle.
- R11: If a supervisor write and a hardware update land in the same cycle, the hardware value wins for the global freeze bit (set) and for the exception enable (cleared). The write's other bits still land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request for the control word |
| wr_data | input | 32 | Data for the control word |
| priv_user | input | 1 | Privilege state: 1 = user state, 0 = supervisor |
| proc_mark | input | 1 | Process mark bit |
| evt | input | 2 | Event strobe per counter |
| ext_cond | input | 1 | External enabled-condition pulse |
| irq_taken | input | 1 | Monitor interrupt taken |
| ctrl_q | output | 32 | Control word, supervisor view |
| ctrl_user_q | output | 32 | Read-only user alias of the control word |
| count_en | output | 1 | Counting permitted this cycle |
| sample_upd_en | output | 1 | Sampled-address update permitted |
| irq_req | output | 1 | Monitor interrupt request pulse |
| priv_viol | output | 1 | Pulse after a user-state write attempt |
| cnt0 | output | CNT_W | Counter 0 value |
| cnt1 | output | CNT_W | Counter 1 value |

## Verification
count_en and sample_upd_en are combinational, so they are due in the same cycle as the inputs that drive them. The bench samples them shortly after it drives the inputs, before the next rising edge. The control word, the counters, irq_req, priv_viol, the automatic freeze set and the exception-enable clear each pass through one register, so they are due one rising edge after the stimulus. The bench checks them at the following falling edge against a model it updates at that same edge. Releasing reset takes two edges through the synchronizer, and the bench waits out that latency before it drives any stimulus.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NUM_CNT = 2;

  // big-endian field numbering: field bit n lives at vector index WORD_W-1-n
  function automatic int unsigned be_bit(input int unsigned n);
    return WORD_W - 1 - n;
  endfunction

  localparam int unsigned POS_FRZ_ALL  = be_bit(0);
  localparam int unsigned POS_FRZ_SUP  = be_bit(1);
  localparam int unsigned POS_FRZ_USR  = be_bit(2);
  localparam int unsigned POS_FRZ_MK1  = be_bit(3);
  localparam int unsigned POS_FRZ_MK0  = be_bit(4);
  localparam int unsigned POS_IRQ_EN   = be_bit(5);
  localparam int unsigned POS_FRZ_COND = be_bit(6);
  localparam int unsigned POS_CE0      = be_bit(16);
  localparam int unsigned POS_CE1      = be_bit(17);
endpackage

// File: rtl/pmon_rst_sync.sv
module pmon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/pmon_ctrl_reg.sv
module pmon_ctrl_reg
  import pmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              priv_user,
  input  logic              hw_set_frz,
  input  logic              hw_clr_irq_en,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              priv_viol
);
  logic [WORD_W-1:0] ctrl_d;
  logic              viol_d;
  logic              wr_ok;

  assign wr_ok = wr_en & ~priv_user;

  // next state: software write first, hardware updates override
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok) ctrl_d = wr_data;
    if (hw_set_frz) ctrl_d[POS_FRZ_ALL] = 1'b1;
    if (hw_clr_irq_en) ctrl_d[POS_IRQ_EN] = 1'b0;
    viol_d = wr_en & priv_user;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      priv_viol <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      priv_viol <= viol_d;
    end
  end
endmodule

// File: rtl/pmon_freeze_gate.sv
module pmon_freeze_gate (
  input  logic frz_all,
  input  logic frz_sup,
  input  logic frz_usr,
  input  logic frz_mk1,
  input  logic frz_mk0,
  input  logic priv_user,
  input  logic proc_mark,
  output logic count_en
);
  logic [4:0] block_vec;

  always_comb begin
    block_vec[0] = frz_all;
    block_vec[1] = frz_sup & ~priv_user;
    block_vec[2] = frz_usr &  priv_user;
    block_vec[3] = frz_mk1 &  proc_mark;
    block_vec[4] = frz_mk0 & ~proc_mark;
    count_en     = ~|block_vec;
  end
endmodule

// File: rtl/pmon_evt_cnt.sv
module pmon_evt_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             msb_rise
);
  localparam logic [CNT_W-1:0] BELOW_HALF = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d    = inc ? cnt_q + 1'b1 : cnt_q;
    msb_rise = inc & (cnt_q == BELOW_HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pmon_freeze_ctrl.sv
module pmon_freeze_ctrl
  import pmon_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               priv_user,
  input  logic               proc_mark,
  input  logic [NUM_CNT-1:0] evt,
  input  logic               ext_cond,
  input  logic               irq_taken,
  output logic [WORD_W-1:0]  ctrl_q,
  output logic [WORD_W-1:0]  ctrl_user_q,
  output logic               count_en,
  output logic               sample_upd_en,
  output logic               irq_req,
  output logic               priv_viol,
  output logic [CNT_W-1:0]   cnt0,
  output logic [CNT_W-1:0]   cnt1
);
  logic               rst_sync_n;
  logic               hw_cond;
  logic               irq_d;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [NUM_CNT-1:0] cnt_rise;
  logic [NUM_CNT-1:0] ce_bits;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  pmon_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pmon_ctrl_reg i_ctrl_reg (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .priv_user     (priv_user),
    .hw_set_frz    (hw_cond & ctrl_q[POS_FRZ_COND]),
    .hw_clr_irq_en (irq_taken),
    .ctrl_q        (ctrl_q),
    .priv_viol     (priv_viol)
  );

  pmon_freeze_gate i_gate (
    .frz_all   (ctrl_q[POS_FRZ_ALL]),
    .frz_sup   (ctrl_q[POS_FRZ_SUP]),
    .frz_usr   (ctrl_q[POS_FRZ_USR]),
    .frz_mk1   (ctrl_q[POS_FRZ_MK1]),
    .frz_mk0   (ctrl_q[POS_FRZ_MK0]),
    .priv_user (priv_user),
    .proc_mark (proc_mark),
    .count_en  (count_en)
  );

  assign ce_bits = {ctrl_q[POS_CE1], ctrl_q[POS_CE0]};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign cnt_inc[g] = evt[g] & count_en;
    pmon_evt_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .inc      (cnt_inc[g]),
      .cnt_q    (cnt_val[g]),
      .msb_rise (cnt_rise[g])
    );
  end

  assign cnt0          = cnt_val[0];
  assign cnt1          = cnt_val[1];
  assign ctrl_user_q   = ctrl_q;
  assign sample_upd_en = ~ctrl_q[POS_FRZ_ALL];
  assign hw_cond       = (|(cnt_rise & ce_bits)) | ext_cond;

  always_comb irq_d = hw_cond & ctrl_q[POS_IRQ_EN];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_req <= 1'b0;
    else             irq_req <= irq_d;
  end
endmodule

// File: rtl/pmon_freeze_chk.sv
module pmon_freeze_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             priv_user,
  input logic             irq_taken,
  input logic             hw_cond,
  input logic [31:0]      ctrl_q,
  input logic             count_en,
  input logic             sample_upd_en,
  input logic             irq_req,
  input logic             priv_viol,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1
);
  // R3
  user_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv_user) |=> priv_viol);

  // R3
  user_wr_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv_user && !hw_cond && !irq_taken) |=> $stable(ctrl_q));

  // R4
  global_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31] |-> (!count_en && !sample_upd_en));

  // R7
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> ($stable(cnt0) && $stable(cnt1)));

  // R8
  cond_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_cond && ctrl_q[25]) |=> ctrl_q[31]);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(ctrl_q[26]));

  // R10
  irq_en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |=> !ctrl_q[26]);
endmodule

bind pmon_freeze_ctrl pmon_freeze_chk #(.CNT_W(CNT_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .wr_en         (wr_en),
  .priv_user     (priv_user),
  .irq_taken     (irq_taken),
  .hw_cond       (hw_cond),
  .ctrl_q        (ctrl_q),
  .count_en      (count_en),
  .sample_upd_en (sample_upd_en),
  .irq_req       (irq_req),
  .priv_viol     (priv_viol),
  .cnt0          (cnt0),
  .cnt1          (cnt1)
);

// File: tb/test_pmon_freeze_ctrl.sv
module test_pmon_freeze_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam logic [CW-1:0] HALF_M1 = 8'd127;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, priv_user, proc_mark, ext_cond, irq_taken;
  logic [31:0] wr_data;
  logic [1:0] evt;
  logic [31:0] ctrl_q, ctrl_user_q;
  logic count_en, sample_upd_en, irq_req, priv_viol;
  logic [CW-1:0] cnt0, cnt1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0]   m_reg;
  logic [CW-1:0] m_cnt [2];
  logic          m_irq, m_viol;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmon_freeze_ctrl #(.CNT_W(CW)) i_pmon_freeze_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .priv_user(priv_user), .proc_mark(proc_mark), .evt(evt),
    .ext_cond(ext_cond), .irq_taken(irq_taken),
    .ctrl_q(ctrl_q), .ctrl_user_q(ctrl_user_q), .count_en(count_en),
    .sample_upd_en(sample_upd_en), .irq_req(irq_req), .priv_viol(priv_viol),
    .cnt0(cnt0), .cnt1(cnt1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_ce(input logic [31:0] r, input logic pu, input logic mk);
    return !(r[31] || (r[30] && !pu) || (r[29] && pu) || (r[28] && mk) || (r[27] && !mk));
  endfunction

  // drive at falling edge, check combinational, advance model and DUT one edge, check registered
  task automatic step(input logic w, input logic [31:0] d, input logic pu, input logic mk,
                      input logic [1:0] ev, input logic ec, input logic tk);
    logic ce, cond;
    logic [1:0] inc, rise;
    logic [31:0] nreg;
    wr_en = w; wr_data = d; priv_user = pu; proc_mark = mk; evt = ev;
    ext_cond = ec; irq_taken = tk;
    #1;
    ce = exp_ce(m_reg, pu, mk);
    chk("R4 R5 R6 R7 count_en", {31'd0, count_en}, {31'd0, ce});
    chk("R4 sample_upd_en", {31'd0, sample_upd_en}, {31'd0, !m_reg[31]});
    for (int k = 0; k < 2; k++) begin
      inc[k]  = ev[k] & ce;
      rise[k] = inc[k] && (m_cnt[k] == HALF_M1);
    end
    cond = (rise[0] & m_reg[15]) | (rise[1] & m_reg[14]) | ec;
    nreg = (w && !pu) ? d : m_reg;
    if (cond && m_reg[25]) nreg[31] = 1'b1;
    if (tk) nreg[26] = 1'b0;
    m_irq  = cond & m_reg[26];
    m_viol = w & pu;
    m_reg  = nreg;
    for (int k = 0; k < 2; k++) if (inc[k]) m_cnt[k] = m_cnt[k] + 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 R8 R10 R11 ctrl_q", ctrl_q, m_reg);
    chk("R2 ctrl_user_q", ctrl_user_q, m_reg);
    chk("R7 cnt0", {24'd0, cnt0}, {24'd0, m_cnt[0]});
    chk("R7 cnt1", {24'd0, cnt1}, {24'd0, m_cnt[1]});
    chk("R9 irq_req", {31'd0, irq_req}, {31'd0, m_irq});
    chk("R3 priv_viol", {31'd0, priv_viol}, {31'd0, m_viol});
  endtask

  task automatic idle(input logic pu, input logic mk, input logic [1:0] ev);
    step(1'b0, 32'd0, pu, mk, ev, 1'b0, 1'b0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 0; wr_data = 0; priv_user = 0; proc_mark = 0;
    evt = 0; ext_cond = 0; irq_taken = 0;
    m_reg = 0; m_cnt[0] = 0; m_cnt[1] = 0; m_irq = 0; m_viol = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ctrl_q", ctrl_q, 32'd0);
    chk("R1 cnt0", {24'd0, cnt0}, 32'd0);
    chk("R1 irq_req", {31'd0, irq_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ctrl after release", ctrl_q, 32'd0);
    chk("R1 priv_viol after release", {31'd0, priv_viol}, 32'd0);

    // R2: supervisor write and read-back; idle keeps it
    step(1'b1, 32'h0012_3456, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    chk("R2 write landed", ctrl_user_q, 32'h0012_3456);
    idle(1'b1, 1'b0, 2'b00);
    chk("R2 idle keeps word", ctrl_q, 32'h0012_3456);

    // R3: user write ignored, one-cycle flag
    step(1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    chk("R3 word unchanged", ctrl_q, 32'h0012_3456);
    chk("R3 flag high", {31'd0, priv_viol}, 32'd1);
    idle(1'b0, 1'b0, 2'b00);
    chk("R3 flag dropped", {31'd0, priv_viol}, 32'd0);

    // R4: global freeze
    step(1'b1, 32'h8000_0000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    idle(1'b0, 1'b0, 2'b11);
    chk("R4 counters frozen", {24'd0, cnt0}, 32'd0);
    // R5: privilege freezes
    step(1'b1, 32'h4000_0000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    idle(1'b0, 1'b0, 2'b01);
    chk("R5 sup-state freeze", {24'd0, cnt0}, 32'd0);
    idle(1'b1, 1'b0, 2'b01);
    chk("R5 user state counts", {24'd0, cnt0}, 32'd1);
    step(1'b1, 32'h2000_0000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    idle(1'b1, 1'b0, 2'b10);
    chk("R5 user-state freeze", {24'd0, cnt1}, 32'd0);
    // R6: mark freezes
    step(1'b1, 32'h1000_0000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    idle(1'b0, 1'b1, 2'b10);
    chk("R6 mark=1 freeze", {24'd0, cnt1}, 32'd0);
    idle(1'b0, 1'b0, 2'b10);
    chk("R6 mark=0 counts", {24'd0, cnt1}, 32'd1);
    step(1'b1, 32'h0800_0000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    idle(1'b0, 1'b0, 2'b10);
    chk("R6 mark=0 freeze", {24'd0, cnt1}, 32'd1);

    // R8 R9: counter 0 crosses into top bit with enable, freeze-on-condition, exception enable
    step(1'b1, 32'h0600_8000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    while (m_cnt[0] != HALF_M1) idle(1'b0, 1'b0, 2'b01);
    chk("R9 no irq before crossing", {31'd0, irq_req}, 32'd0);
    idle(1'b0, 1'b0, 2'b01);
    chk("R8 freeze set", {31'd0, ctrl_q[31]}, 32'd1);
    chk("R9 irq pulse", {31'd0, irq_req}, 32'd1);
    chk("R7 reached half", {24'd0, cnt0}, 32'd128);
    idle(1'b0, 1'b0, 2'b01);
    chk("R9 irq one cycle", {31'd0, irq_req}, 32'd0);
    // R10
    step(1'b0, 32'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
    chk("R10 enable cleared", {31'd0, ctrl_q[26]}, 32'd0);

    // R11: write vs hardware
    step(1'b1, 32'h0200_0000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    step(1'b1, 32'h0200_0001, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
    chk("R11 hw freeze wins", ctrl_q, 32'h8200_0001);
    step(1'b1, 32'h0400_0002, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
    chk("R11 hw clear wins", ctrl_q, 32'h0000_0002);
    // R9: condition without exception enable
    step(1'b0, 32'd0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
    chk("R9 gated off", {31'd0, irq_req}, 32'd0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic w;
      w = ($urandom % 10) == 0;
      d = $urandom;
      for (int b = 27; b < 32; b++) if (($urandom % 4) != 0) d[b] = 1'b0;
      step(w, d, 1'($urandom), 1'($urandom), 2'($urandom),
           ($urandom % 32) == 0, ($urandom % 16) == 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule